// File: doc/BRIEF.md
# Serial Sampling Converter Port Model

This block is a synthesizable model of the digital side of a serial sampling converter. It runs on a fast system clock. Its two control pins are asynchronous to that clock, so it synchronizes them and detects their rising edges. A rising edge on the start pin begins a conversion, captures a parallel sample word, and then presents that word one bit at a time on a serial output pin, advanced by the rising edges of the shift clock pin.

The block also tracks two low-power states, nap and sleep. They are entered by bursts of start-pin edges that arrive with no shift-clock edge between them. Any shift-clock edge returns the block to the active state. The sample word has no back-pressure: it is taken as-is in the cycle a conversion is accepted, and the block never stalls the source. The serial output likewise runs only when the host supplies shift-clock edges. Control and status pins are plain levels.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `serial_out` is 0, `pwr_state` is 2'b00 (active) and `conv_busy` is 0.
- R2: A start-pin rising edge while active and not busy begins a conversion. `conv_busy` goes to 1 and `serial_out` goes to 0. The value of `sample_word` in that cycle is captured, and later changes to `sample_word` do not alter the frame.
- R3: While busy, further start-pin rising edges do not restart the frame. `conv_busy` stays 1 until the 16th shift-clock rising edge after the start and falls on that edge.
- R4: On shift-clock rising edge k of a frame, `serial_out` shows captured bit DATA_W-1-(k-3) for k from 3 to 2+DATA_W. The most significant bit comes first, and DATA_W is 12 or 14 (14 by default). `serial_out` changes only on an edge.
- R5: `serial_out` is 0 on shift edges 1 and 2 of a frame, on edges past 2+DATA_W, on any shift edge while idle, and after a start.
- R6: Two start-pin rising edges with no shift-clock rising edge between them put the block in nap (`pwr_state` 2'b01). Entering nap abandons any frame in progress, which clears `conv_busy` and drives `serial_out` to 0.
- R7: Four such edges put the block in sleep (`pwr_state` 2'b10). In other words, two more edges take it from nap to sleep, and further edges keep it in sleep. The code 2'b11 never appears.
- R8: Any shift-clock rising edge returns `pwr_state` to active and restarts the count of start-pin edges.
- R9: A start-pin edge received in nap or sleep starts no conversion; `conv_busy` stays 0.
- R10: After a single waking shift-clock edge, the next start-pin edge starts a conversion whose frame follows R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pin | input | 1 | Asynchronous conversion start pin |
| shift_clk | input | 1 | Asynchronous serial shift clock pin |
| sample_word | input | DATA_W | Parallel sample captured at a conversion start |
| serial_out | output | 1 | Serial data, most significant bit first |
| pwr_state | output | 2 | 00 active, 01 nap, 10 sleep |
| conv_busy | output | 1 | High from an accepted start until the 16th shift edge |

## Verification
Every result is due three system-clock edges after a pin changes: two synchronizer flops, then the state register that acts on the detected edge. The bench changes pins only on falling clock edges. It then waits four full clock periods before it samples, so every output has settled and no check lands on an edge where an output is changing. A sweep of sample words runs complete frames, some of them with a locked-out start edge in the middle. Directed sequences then step through nap, sleep and wake one pin edge at a time and check the state after each edge.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_NAP    = 2'b01,
    PWR_SLEEP  = 2'b10
  } pwr_e;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/adc_power_fsm.sv
module adc_power_fsm
  import adc_port_pkg::*;
#(
  parameter int NAP_EDGES   = 2,
  parameter int SLEEP_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rise,
  input  logic shift_rise,
  output pwr_e state,
  output logic lp_enter
);
  localparam int CNT_W = $clog2(SLEEP_EDGES + 1);

  logic [CNT_W-1:0] idle_cnt;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    if (idle_cnt == CNT_W'(SLEEP_EDGES)) cnt_inc = idle_cnt;
    else                                 cnt_inc = idle_cnt + CNT_W'(1);
    lp_enter = start_rise & ~shift_rise & (cnt_inc >= CNT_W'(NAP_EDGES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      state    <= PWR_ACTIVE;
    end else if (shift_rise) begin
      idle_cnt <= start_rise ? CNT_W'(1) : '0;
      state    <= PWR_ACTIVE;
    end else if (start_rise) begin
      idle_cnt <= cnt_inc;
      if (cnt_inc >= CNT_W'(SLEEP_EDGES))    state <= PWR_SLEEP;
      else if (cnt_inc >= CNT_W'(NAP_EDGES)) state <= PWR_NAP;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int DATA_W     = 14,
  parameter int LOCK_EDGES = 16,
  parameter int LEAD_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rise,
  input  logic              shift_rise,
  input  logic              active,
  input  logic              abort,
  input  logic [DATA_W-1:0] sample,
  output logic              busy,
  output logic              sdo
);
  localparam int EC_W  = $clog2(LOCK_EDGES + 1);
  localparam int FIRST = LEAD_EDGES + 1;
  localparam int LAST  = LEAD_EDGES + DATA_W;

  logic [EC_W-1:0]   edge_cnt;
  logic [EC_W-1:0]   nxt_cnt;
  logic [DATA_W-1:0] shreg;
  logic              start;
  logic              in_window;

  always_comb begin
    nxt_cnt   = edge_cnt + EC_W'(1);
    start     = start_rise & ~busy & active & ~abort;
    in_window = (nxt_cnt >= EC_W'(FIRST)) && (nxt_cnt <= EC_W'(LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sdo      <= 1'b0;
      edge_cnt <= '0;
      shreg    <= '0;
    end else if (abort) begin
      busy     <= 1'b0;
      sdo      <= 1'b0;
      edge_cnt <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      sdo      <= 1'b0;
      edge_cnt <= '0;
      shreg    <= sample;
    end else if (shift_rise) begin
      if (busy) begin
        edge_cnt <= nxt_cnt;
        if (in_window) begin
          sdo   <= shreg[DATA_W-1];
          shreg <= {shreg[DATA_W-2:0], 1'b0};
        end else begin
          sdo <= 1'b0;
        end
        if (nxt_cnt == EC_W'(LOCK_EDGES)) busy <= 1'b0;
      end else begin
        sdo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_EDGES  = 16,
  parameter int LEAD_EDGES  = 2,
  parameter int NAP_EDGES   = 2,
  parameter int SLEEP_EDGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pin,
  input  logic              shift_clk,
  input  logic [DATA_W-1:0] sample_word,
  output logic              serial_out,
  output logic [1:0]        pwr_state,
  output logic              conv_busy
);
  logic start_rise;
  logic shift_rise;
  logic lp_enter;
  pwr_e pstate;

  adc_pin_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(start_pin), .rise(start_rise)
  );

  adc_pin_sync #(.STAGES(SYNC_STAGES)) u_shift_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(shift_clk), .rise(shift_rise)
  );

  adc_power_fsm #(.NAP_EDGES(NAP_EDGES), .SLEEP_EDGES(SLEEP_EDGES)) u_power (
    .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .shift_rise(shift_rise),
    .state(pstate), .lp_enter(lp_enter)
  );

  adc_conv_ctrl #(.DATA_W(DATA_W), .LOCK_EDGES(LOCK_EDGES),
                  .LEAD_EDGES(LEAD_EDGES)) u_conv (
    .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .shift_rise(shift_rise),
    .active(pstate == PWR_ACTIVE), .abort(lp_enter), .sample(sample_word),
    .busy(conv_busy), .sdo(serial_out)
  );

  assign pwr_state = pstate;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_rise,
  input logic       shift_rise,
  input logic       conv_busy,
  input logic       serial_out,
  input logic [1:0] pwr_state
);
  // R6
  lp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b00 |-> !conv_busy && !serial_out);

  // R8
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> pwr_state == 2'b00);

  // R9
  lp_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise && !shift_rise && pwr_state != 2'b00 |=> !conv_busy);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise && !shift_rise && !conv_busy && pwr_state == 2'b00
      |=> conv_busy && !serial_out);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && !shift_rise && !start_rise |=> conv_busy);

  // R7
  pwr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);

  // R6
  pwr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise && !start_rise |=> $stable(pwr_state));

  // R4
  sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise && !start_rise |=> $stable(serial_out));
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .shift_rise(shift_rise),
  .conv_busy(conv_busy), .serial_out(serial_out), .pwr_state(pwr_state)
);

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;
  localparam int DW = 14;
  localparam int SETTLE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_pin = 1'b0;
  logic          shift_clk = 1'b0;
  logic [DW-1:0] sample_word = '0;
  logic          serial_out;
  logic [1:0]    pwr_state;
  logic          conv_busy;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  adc_serial_port #(.DATA_W(DW)) u_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .shift_clk(shift_clk),
    .sample_word(sample_word), .serial_out(serial_out),
    .pwr_state(pwr_state), .conv_busy(conv_busy)
  );

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_pulse();
    start_pin = 1'b1; settle();
    start_pin = 1'b0; settle();
  endtask

  task automatic shift_pulse();
    shift_clk = 1'b1; settle();
    shift_clk = 1'b0; settle();
  endtask

  function automatic logic exp_bit(input logic [DW-1:0] w, input int k);
    if (k >= 3 && k <= 2 + DW) return w[DW-1-(k-3)];
    return 1'b0;
  endfunction

  // One full frame: start, 16 shift edges, one trailing edge.
  task automatic run_frame(input logic [DW-1:0] w, input bit mid_start, input string tag);
    sample_word = w;
    start_pin = 1'b1; settle();
    chk({tag, " R2 busy after start"}, conv_busy, 1);
    chk({tag, " R5 sdo low after start"}, serial_out, 0);
    sample_word = ~w;
    start_pin = 1'b0; settle();
    for (int k = 1; k <= 16; k++) begin
      shift_clk = 1'b1; settle();
      chk({tag, " R4 R5 sdo bit"}, serial_out, exp_bit(w, k));
      if (mid_start && k == 5) begin
        start_pulse();
        chk({tag, " R3 locked-out start"}, conv_busy, 1);
        chk({tag, " R3 sdo kept"}, serial_out, exp_bit(w, k));
      end
      shift_clk = 1'b0; settle();
      chk({tag, " R3 busy window"}, conv_busy, (k < 16) ? 1 : 0);
    end
    shift_pulse();
    chk({tag, " R5 sdo low idle edge"}, serial_out, 0);
    chk({tag, " R3 idle"}, conv_busy, 0);
    chk({tag, " R8 active"}, pwr_state, 2'b00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R1 sdo reset", serial_out, 0);
    chk("R1 pwr reset", pwr_state, 2'b00);
    chk("R1 busy reset", conv_busy, 0);
    rst_n = 1'b1;
    settle();
    chk("R1 sdo after release", serial_out, 0);

    // Sweep of sample words, odd entries carry a mid-frame start edge.
    for (int i = 0; i < 40; i++) begin
      logic [DW-1:0] w;
      if (i == 0)      w = '0;
      else if (i == 1) w = '1;
      else             w = DW'((i * 32'h2F5B + 32'h1357) ^ (i << 7));
      run_frame(w, i[0], "sweep");
    end

    // Nap, sleep, wake sequence.
    start_pulse();
    chk("R2 first start busy", conv_busy, 1);
    chk("R2 still active", pwr_state, 2'b00);
    start_pulse();
    chk("R6 nap entered", pwr_state, 2'b01);
    chk("R6 frame abandoned", conv_busy, 0);
    chk("R6 sdo low", serial_out, 0);
    start_pulse();
    chk("R6 nap held", pwr_state, 2'b01);
    chk("R9 no start in nap", conv_busy, 0);
    start_pulse();
    chk("R7 sleep entered", pwr_state, 2'b10);
    chk("R9 no start in sleep", conv_busy, 0);
    start_pulse();
    chk("R7 sleep held", pwr_state, 2'b10);
    chk("R9 sleep no busy", conv_busy, 0);
    shift_pulse();
    chk("R8 wake from sleep", pwr_state, 2'b00);
    chk("R8 idle after wake", conv_busy, 0);
    chk("R5 sdo low on wake", serial_out, 0);
    run_frame(DW'(14'h2A5C), 1'b0, "R10 after sleep");

    // Nap then wake.
    start_pulse();
    start_pulse();
    chk("R6 nap again", pwr_state, 2'b01);
    shift_pulse();
    chk("R8 wake from nap", pwr_state, 2'b00);
    run_frame(DW'(14'h1C3B), 1'b1, "R10 after nap");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule